// File: doc/BRIEF.md
# Motor Speed Lock and Stall Supervisor

This block checks a digitized motor-speed square wave against a reference tick stream. It counts reference ticks across each full speed period and compares that count with an expected value. From this it reports whether the motor runs inside a ±5% band, and it reports when the motor runs too fast for a coast function to act on. An active-low lock pin follows the in-band state.

A missing-pulse watchdog detects a motor that has stopped producing edges. When it fires, it forces a full-scale "speed up" error to the loop and declares the motor out of lock. A stall timer counts ticks of a slow oscillator for as long as the motor stays out of lock. When the timer reaches its limit, it sets a shutdown latch. The `clear` output holds the gate drivers off while any of these is true: the latch is set, the power-up delay is still running, the supply is low, or the charge pump is low.

The speed pulse, start/stop, supply-ok and charge-pump-ok inputs are asynchronous. Each one is synchronized inside the block. All tick inputs are single-cycle strobes in the block's own clock domain.

Top module: `speed_lock_supervisor`

## Requirements
- R1: While reset is held, and right after it, `lock_n` is 1, `out_of_lock` is 1, `err_force_up` is 0, `over_speed` is 0 and `clear` is 1.
- R2: At every rising edge of the synchronized speed pulse after the first, the number of `ref_tick` strobes since the previous rising edge is judged. Lock holds (`lock_n`=0, `out_of_lock`=0) when that count lies in the range from `exp_count - floor(exp_count/20)` to `exp_count + floor(exp_count/20)`, both bounds included. The verdict holds until the next rising edge.
- R3: `over_speed` is 1 when the judged count is below the lower bound and the watchdog has not fired. A locked motor never shows `over_speed`.
- R4: After WD_LIMIT (default 512) `pwm_tick` strobes with no transition of the speed pulse, `err_force_up` goes to 1 and `out_of_lock` goes to 1. Both stay that way until the next transition of the speed pulse.
- R5: While `out_of_lock` is 1, each `lt_tick` advances the stall counter. When the counter reaches LT_LIMIT (default 1023), the shutdown latch sets and `clear` goes to 1.
- R6: A high synchronized `start_stop`, or a low synchronized `supply_ok`, returns the stall counter to zero and holds it there.
- R7: Once set, the shutdown latch stays set while `start_stop` is high. It is released only when `start_stop` falls after having been high. If the stall persists, the latch sets again after a further full count.
- R8: After `supply_ok` rises, `clear` stays 1 until PUC_TICKS (default 3) `puc_tick` strobes have arrived, and for as long as `cp_ok` is low.
- R9: A low `cp_ok` forces `clear` to 1 without latching. `clear` returns to 0 once `cp_ok` is high again.
- R10: A low `supply_ok` releases the shutdown latch. After power returns, `clear` depends only on the power-up delay and the charge pump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_in | input | 1 | Digitized speed pulse, asynchronous |
| ref_tick | input | 1 | Reference clock strobe |
| pwm_tick | input | 1 | PWM-rate strobe that drives the watchdog |
| lt_tick | input | 1 | Lock-timer oscillator strobe |
| puc_tick | input | 1 | Power-up delay strobe, about 20 kHz |
| start_stop | input | 1 | High = stop; asynchronous |
| supply_ok | input | 1 | Logic supply above its undervoltage threshold, asynchronous |
| cp_ok | input | 1 | Charge pump above its undervoltage threshold, asynchronous |
| exp_count | input | CNT_W | Expected reference ticks per speed period |
| lock_n | output | 1 | Active-low in-band indication |
| out_of_lock | output | 1 | Speed outside the band, or watchdog fired |
| err_force_up | output | 1 | Watchdog fired: force full-scale up error |
| over_speed | output | 1 | Measured period shorter than the lower bound |
| clear | output | 1 | Holds the gate drivers in their off state |

## Verification
Some properties are checked by assertions on every cycle:
- the lock verdict changes only at a judged speed edge;
- the watchdog and stall counters never run past their limits, and they move only when their strobes allow it;
- a high stop input empties the stall counter;
- the latch holds until a stop release or a supply loss;
- `clear` is raised whenever the power-up delay is pending or the charge pump is low;
- over-speed never appears together with lock.

The exact window edges (counts 38, 42, 43 and 37 for an expected count of 40) can only be shown by the bench's directed scenarios. The same holds for the watchdog firing after a stopped motor, the stall timeout landing near its 1023rd tick, relatching after a release, and the power-up tick count.

// File: rtl/speed_sup_pkg.sv
// Shared types and helpers for the speed lock supervisor.
// Assumes: counts are unsigned; the window half-width is one twentieth, rounded down.
package speed_sup_pkg;

    // Verdict produced at each judged speed edge.
    typedef struct packed {
        logic in_band;
        logic too_fast;
    } verdict_t;

    // Half-width of the lock band: floor(expected / 20).
    function automatic int unsigned band_step(input int unsigned expected);
        return expected / 20;
    endfunction

endpackage

// File: rtl/sync_2ff.sv
// Two-flop synchronizer for a bundle of independent asynchronous bits.
// Assumes: the bits are unrelated, so per-bit skew between them is acceptable.
module sync_2ff #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit, both reset to 0.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/period_meter.sv
// Measures speed period in reference ticks, judges it against a +/-5% band,
// and runs the missing-pulse watchdog.
// Assumes: spd is already synchronized; ref_tick and pwm_tick are one-cycle strobes.
module period_meter
    import speed_sup_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int WD_LIMIT = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spd,
    input  logic             ref_tick,
    input  logic             pwm_tick,
    input  logic [CNT_W-1:0] exp_count,
    output logic             locked,
    output logic             fast,
    output logic             wd_fired
);
    localparam int WD_W = $clog2(WD_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             spd_d;
    logic             rise, toggle;
    logic             primed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   lo_b, hi_b, step;
    verdict_t         verdict;
    logic [WD_W-1:0]  wd_cnt;

    assign rise   = spd & ~spd_d;
    assign toggle = spd ^ spd_d;

    // Band bounds; hi uses one extra bit so it cannot wrap.
    always_comb begin
        step = (CNT_W+1)'(band_step(int'(exp_count)));
        lo_b = {1'b0, exp_count} - step;
        hi_b = {1'b0, exp_count} + step;
    end

    // Delay of the speed level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) spd_d <= 1'b0;
        else        spd_d <= spd;
    end

    // Reference tick counter, restarted at each rising edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (rise)                     cnt <= ref_tick ? CNT_W'(1) : '0;
        else if (ref_tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Verdict taken at every rising edge after the first one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed  <= 1'b0;
            verdict <= '0;
        end else if (rise) begin
            primed <= 1'b1;
            if (primed) begin
                verdict.in_band  <= ({1'b0, cnt} >= lo_b) && ({1'b0, cnt} <= hi_b);
                verdict.too_fast <= ({1'b0, cnt} <  lo_b);
            end
        end
    end

    // Watchdog: PWM ticks since the last speed transition, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                wd_cnt <= '0;
        else if (toggle)                           wd_cnt <= '0;
        else if (pwm_tick && wd_cnt != WD_W'(WD_LIMIT)) wd_cnt <= wd_cnt + 1'b1;
    end

    assign wd_fired = (wd_cnt == WD_W'(WD_LIMIT));
    assign locked   = verdict.in_band  & ~wd_fired;
    assign fast     = verdict.too_fast & ~wd_fired;

    a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(verdict));
    a_r4_wd_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wd_cnt <= WD_W'(WD_LIMIT));
    a_r4_wd_restart: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> !wd_fired);
endmodule

// File: rtl/stall_timer.sv
// Counts lock-oscillator ticks while out of lock; flags a timeout at the limit.
// Assumes: hold_clr is synchronized; lt_tick is a one-cycle strobe.
module stall_timer #(
    parameter int LT_LIMIT = 1023
) (
    input  logic clk,
    input  logic rst_n,
    input  logic out_of_lock,
    input  logic lt_tick,
    input  logic hold_clr,
    output logic timeout
);
    localparam int LT_W = $clog2(LT_LIMIT + 1);

    logic [LT_W-1:0] lt_cnt;

    // Stall counter: cleared by stop or low supply, stops at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      lt_cnt <= '0;
        else if (hold_clr)               lt_cnt <= '0;
        else if (out_of_lock && lt_tick && lt_cnt != LT_W'(LT_LIMIT))
                                         lt_cnt <= lt_cnt + 1'b1;
    end

    assign timeout = (lt_cnt == LT_W'(LT_LIMIT));

    a_r5_count_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_clr && !(out_of_lock && lt_tick)) |=> $stable(lt_cnt));
    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (lt_cnt == '0));
    a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        lt_cnt <= LT_W'(LT_LIMIT));
endmodule

// File: rtl/shutdown_ctrl.sv
// Power-up delay, shutdown latch and the gate-driver clear output.
// Assumes: sup_ok, cp_ok and stop are synchronized; puc_tick is a one-cycle strobe.
module shutdown_ctrl #(
    parameter int PUC_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    input  logic cp_ok,
    input  logic stop,
    input  logic puc_tick,
    input  logic timeout,
    output logic clear
);
    localparam int PUC_W = $clog2(PUC_TICKS + 1);

    logic             stop_d;
    logic             stop_fall;
    logic             latched;
    logic [PUC_W-1:0] puc_cnt;
    logic             puc_done;

    assign stop_fall = stop_d & ~stop;
    assign puc_done  = (puc_cnt == PUC_W'(PUC_TICKS));

    // Delayed stop level for release-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_d <= 1'b0;
        else        stop_d <= stop;
    end

    // Power-up delay: counts puc ticks while the supply is good.
    always_ff @(posedge clk) begin
        if (!rst_n || !sup_ok)            puc_cnt <= '0;
        else if (puc_tick && !puc_done)   puc_cnt <= puc_cnt + 1'b1;
    end

    // Shutdown latch: set by timeout, released by a stop release or a supply loss.
    always_ff @(posedge clk) begin
        if (!rst_n || !sup_ok) latched <= 1'b0;
        else if (stop_fall)    latched <= 1'b0;
        else if (timeout)      latched <= 1'b1;
    end

    // Clear output: any latched or unlatched shutdown cause.
    always_ff @(posedge clk) begin
        if (!rst_n) clear <= 1'b1;
        else        clear <= !sup_ok || !puc_done || !cp_ok || latched;
    end

    a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && sup_ok && !stop_fall) |=> latched);
    a_r8_puc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !puc_done |=> clear);
    a_r9_cp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_ok |=> clear);
    a_r10_supply_release: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> !latched);
endmodule

// File: rtl/speed_lock_supervisor.sv
// Top level: synchronizes the asynchronous inputs, then wires the period meter,
// the stall timer and the shutdown controller together.
// Assumes: every *_tick input is a one-cycle strobe in the clk domain.
module speed_lock_supervisor #(
    parameter int CNT_W     = 16,
    parameter int WD_LIMIT  = 512,
    parameter int LT_LIMIT  = 1023,
    parameter int PUC_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             speed_in,
    input  logic             ref_tick,
    input  logic             pwm_tick,
    input  logic             lt_tick,
    input  logic             puc_tick,
    input  logic             start_stop,
    input  logic             supply_ok,
    input  logic             cp_ok,
    input  logic [CNT_W-1:0] exp_count,
    output logic             lock_n,
    output logic             out_of_lock,
    output logic             err_force_up,
    output logic             over_speed,
    output logic             clear
);
    logic [3:0] async_in, async_s;
    logic       spd_s, stop_s, sup_s, cp_s;
    logic       locked, fast, wd_fired, timeout;

    assign async_in = {cp_ok, supply_ok, start_stop, speed_in};
    assign {cp_s, sup_s, stop_s, spd_s} = async_s;

    sync_2ff #(.W(4)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(async_in), .q(async_s)
    );

    period_meter #(.CNT_W(CNT_W), .WD_LIMIT(WD_LIMIT)) i_meter (
        .clk(clk), .rst_n(rst_n), .spd(spd_s), .ref_tick(ref_tick),
        .pwm_tick(pwm_tick), .exp_count(exp_count),
        .locked(locked), .fast(fast), .wd_fired(wd_fired)
    );

    stall_timer #(.LT_LIMIT(LT_LIMIT)) i_stall (
        .clk(clk), .rst_n(rst_n), .out_of_lock(!locked), .lt_tick(lt_tick),
        .hold_clr(stop_s || !sup_s), .timeout(timeout)
    );

    shutdown_ctrl #(.PUC_TICKS(PUC_TICKS)) i_shut (
        .clk(clk), .rst_n(rst_n), .sup_ok(sup_s), .cp_ok(cp_s), .stop(stop_s),
        .puc_tick(puc_tick), .timeout(timeout), .clear(clear)
    );

    assign lock_n       = ~locked;
    assign out_of_lock  = ~locked;
    assign err_force_up = wd_fired;
    assign over_speed   = fast;

    a_r3_fast_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
        over_speed |-> lock_n);
    a_r4_wd_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        err_force_up |-> out_of_lock);
endmodule

// File: tb/test_speed_lock_supervisor.sv
// Directed bench for the speed lock supervisor: one task per scenario.
module test_speed_lock_supervisor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        speed_in = 1'b0;
    logic        ref_tick = 1'b1;
    logic        pwm_tick = 1'b1;
    logic        lt_tick = 1'b0;
    logic        puc_tick = 1'b0;
    logic        start_stop = 1'b0;
    logic        supply_ok = 1'b0;
    logic        cp_ok = 1'b1;
    logic [15:0] exp_count = 16'd40;
    logic        lock_n, out_of_lock, err_force_up, over_speed, clear;

    int checks = 0;
    int failures = 0;
    int per = 40;
    bit spin = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    speed_lock_supervisor i_speed_lock_supervisor (
        .clk(clk), .rst_n(rst_n), .speed_in(speed_in), .ref_tick(ref_tick),
        .pwm_tick(pwm_tick), .lt_tick(lt_tick), .puc_tick(puc_tick),
        .start_stop(start_stop), .supply_ok(supply_ok), .cp_ok(cp_ok),
        .exp_count(exp_count), .lock_n(lock_n), .out_of_lock(out_of_lock),
        .err_force_up(err_force_up), .over_speed(over_speed), .clear(clear)
    );

    // Speed pulse generator: period 'per' cycles while 'spin' is set.
    initial begin
        forever begin
            if (spin) begin
                speed_in = 1'b1;
                repeat (per / 2) @(negedge clk);
                speed_in = 1'b0;
                repeat (per - per / 2) @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_puc();
        @(negedge clk) puc_tick = 1'b1;
        @(negedge clk) puc_tick = 1'b0;
    endtask

    // R1: reset values.
    task automatic t_reset();
        wait_cyc(4);
        check("R1 lock_n", lock_n, 1);
        check("R1 out_of_lock", out_of_lock, 1);
        check("R1 err_force_up", err_force_up, 0);
        check("R1 over_speed", over_speed, 0);
        check("R1 clear", clear, 1);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1 clear after reset", clear, 1);
    endtask

    // R8/R9: power-up delay and charge pump gating.
    task automatic t_powerup();
        supply_ok = 1'b1;
        wait_cyc(5);
        pulse_puc(); pulse_puc();
        wait_cyc(4);
        check("R8 clear after two puc ticks", clear, 1);
        pulse_puc();
        wait_cyc(4);
        check("R8 clear after three puc ticks", clear, 0);
        cp_ok = 1'b0;
        wait_cyc(5);
        check("R9 clear on charge pump low", clear, 1);
        cp_ok = 1'b1;
        wait_cyc(5);
        check("R9 clear drops when charge pump recovers", clear, 0);
    endtask

    // R2/R3: one period length, judged after several periods.
    task automatic t_period(input int p, input int exp_lock, input int exp_fast);
        per = p;
        spin = 1'b1;
        wait_cyc(4 * 45 + 5);
        check($sformatf("R2 lock_n period %0d", p), lock_n, exp_lock ? 0 : 1);
        check($sformatf("R2 out_of_lock period %0d", p), out_of_lock, exp_lock ? 0 : 1);
        check($sformatf("R3 over_speed period %0d", p), over_speed, exp_fast);
    endtask

    // R4: missing-pulse watchdog.
    task automatic t_watchdog();
        per = 40;
        wait_cyc(200);
        check("R4 no error while running", err_force_up, 0);
        spin = 1'b0;
        wait_cyc(400);
        check("R4 no error before limit", err_force_up, 0);
        wait_cyc(200);
        check("R4 error after limit", err_force_up, 1);
        check("R4 out_of_lock after limit", out_of_lock, 1);
        spin = 1'b1;
        wait_cyc(50);
        check("R4 error cleared by transition", err_force_up, 0);
        spin = 1'b0;
        wait_cyc(600);
        check("R4 out_of_lock while stopped", out_of_lock, 1);
    endtask

    // R5/R6/R7: stall timeout, stop hold, release and relatch.
    task automatic t_stall();
        start_stop = 1'b1;
        wait_cyc(5);
        start_stop = 1'b0;
        wait_cyc(5);
        lt_tick = 1'b1;
        wait_cyc(1000);
        check("R5 no shutdown before limit", clear, 0);
        wait_cyc(40);
        check("R5 shutdown at limit", clear, 1);
        start_stop = 1'b1;
        wait_cyc(20);
        check("R7 latch holds while stop high", clear, 1);
        start_stop = 1'b0;
        wait_cyc(6);
        check("R7 released by stop high then low", clear, 0);
        wait_cyc(994);
        check("R6 counter restarted from zero", clear, 0);
        wait_cyc(40);
        check("R7 relatch on persisting stall", clear, 1);
        lt_tick = 1'b0;
    endtask

    // R10/R8: supply loss releases the latch; power-up delay repeats.
    task automatic t_power_cycle();
        supply_ok = 1'b0;
        wait_cyc(5);
        check("R10 clear while supply low", clear, 1);
        supply_ok = 1'b1;
        wait_cyc(5);
        pulse_puc(); pulse_puc();
        wait_cyc(4);
        check("R8 delay repeats after power cycle", clear, 1);
        pulse_puc();
        wait_cyc(4);
        check("R10 latch released by power cycle", clear, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_powerup();
        t_period(40, 1, 0);
        t_period(42, 1, 0);
        t_period(43, 0, 0);
        t_period(38, 1, 0);
        t_period(37, 0, 1);
        t_watchdog();
        t_stall();
        t_power_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule